// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a system-on-chip. Software sees six 32-bit registers on a simple single-cycle register bus. It turns the watchdog on once, picks a timeout range and then has to keep the counter from running out. The counter is a down-counter. Its period is two raised to a base exponent plus a 4-bit range value. Software restarts it by writing a fixed key. Once on, the watchdog cannot be turned off except by the block's own reset.

When the counter runs out, the block acts according to a response-mode bit. With the bit set, the first expiry raises an interrupt. A second expiry that comes while that interrupt is still pending drives a system reset pulse. With the bit clear, an expiry drives the reset pulse at once. Reading the acknowledge register clears a pending interrupt and restarts the counter.

A small state machine controls the response:
- `ST_OFF` leaves to `ST_RUN` once the enable bit is set.
- From `ST_RUN`, an expiry goes to `ST_IRQ` in interrupt mode and to `ST_RST` in direct mode.
- From `ST_IRQ`, an acknowledge read returns to `ST_RUN`, and a further expiry goes to `ST_RST`.
- `ST_RST` returns to `ST_RUN` after the pulse length.

Top module: `wdog_periph`

## Requirements
- R1: The register offsets are fixed:
  - control at 0x00: bit 0 is enable, bit 1 is response mode.
  - range at 0x04: bits 3:0.
  - live count at 0x08.
  - restart at 0x0C.
  - status at 0x10: bit 0 is interrupt pending.
  - acknowledge at 0x14: reads as 0.

  The control and range registers read back what was written. Reads from any unmapped offset return 0.
- R2: Once the enable bit is 1, no write can clear it. Only rst_n clears it.
- R3: After reset the count reads 0. While the enable bit is 0 the count holds, and restart writes and acknowledge reads have no effect.
- R4: When the enable bit goes from 0 to 1, the counter loads 2^(BASE_EXP+range)-1. It then falls by one on every clock. On the cycle after it reads 0, it reloads.
- R5: Writing exactly 0x76 to the restart register reloads the counter on the next clock. Any other value written there is ignored.
- R6: A new range value takes effect only at the next reload. The count already running is not changed.
- R7: In interrupt mode (mode=1), an expiry in `ST_RUN` sets irq_o and status bit 0 one clock later.
- R8: A read of the acknowledge register while an interrupt is pending clears irq_o on the next clock and reloads the counter.
- R9: In interrupt mode, an expiry while the interrupt is pending does two things:
  - it drives sys_rst_o high for exactly PULSE_LEN (8) cycles;
  - it drops irq_o.
- R10: In direct mode (mode=0), an expiry drives sys_rst_o for PULSE_LEN cycles and irq_o never rises.
- R11: Writes to the count, status and acknowledge registers have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_sel | input | 1 | Selects the block for this cycle's access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (acknowledge reads have a side effect) |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq_o | output | 1 | Timeout interrupt, high while pending |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with BASE_EXP=2, so range 1 gives an 8-cycle period and range 0 gives a 4-cycle period. With periods that short, the bench can reach several things within a few dozen cycles:
- reload on first enable and on the restart key;
- range changes that wait for the next reload;
- the escalation from interrupt to reset, with every cycle predicted exactly.

PULSE_LEN stays at 8, so the bench can measure the full reset pulse. It also exercises a second expiry that falls inside the pulse and must be ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [7:0]  OFF_CTRL    = 8'h00;
    localparam logic [7:0]  OFF_RANGE   = 8'h04;
    localparam logic [7:0]  OFF_COUNT   = 8'h08;
    localparam logic [7:0]  OFF_RESTART = 8'h0C;
    localparam logic [7:0]  OFF_STATUS  = 8'h10;
    localparam logic [7:0]  OFF_ACK     = 8'h14;
    localparam logic [31:0] RESTART_KEY = 32'h0000_0076;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RUN = 2'd1,
        ST_IRQ = 2'd2,
        ST_RST = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int RANGE_W = 4,
    parameter int CNT_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [CNT_W-1:0]   cnt_val,
    input  logic               irq_pend,
    output logic [31:0]        bus_rdata,
    output logic               en_q,
    output logic               mode_q,
    output logic [RANGE_W-1:0] range_q,
    output logic               en_set,
    output logic               kick,
    output logic               ack_rd
);
    logic [7:0] off;
    logic       wr_hit, rd_hit;

    assign off    = 8'(bus_addr);
    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && bus_rd;

    assign en_set = wr_hit && (off == OFF_CTRL) && bus_wdata[0] && !en_q;
    assign kick   = wr_hit && (off == OFF_RESTART) && (bus_wdata == RESTART_KEY) && en_q;
    assign ack_rd = rd_hit && (off == OFF_ACK) && en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= 1'b0;
            range_q <= '0;
        end else if (wr_hit) begin
            if (off == OFF_CTRL) begin
                en_q   <= en_q | bus_wdata[0];
                mode_q <= bus_wdata[1];
            end
            if (off == OFF_RANGE) begin
                range_q <= bus_wdata[RANGE_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (off)
            OFF_CTRL:   bus_rdata = {30'd0, mode_q, en_q};
            OFF_RANGE:  bus_rdata = 32'(range_q);
            OFF_COUNT:  bus_rdata = 32'(cnt_val);
            OFF_STATUS: bus_rdata = {31'd0, irq_pend};
            default:    bus_rdata = '0;
        endcase
    end

    p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int BASE_EXP = 16,
    parameter int RANGE_W  = 4,
    parameter int CNT_W    = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               load,
    input  logic [RANGE_W-1:0] range,
    output logic [CNT_W-1:0]   cnt,
    output logic               expire
);
    localparam int SH_W = $clog2(CNT_W) + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [SH_W-1:0]  shamt;
    logic [CNT_W-1:0] load_val;

    assign shamt    = SH_W'(BASE_EXP) + SH_W'(range);
    assign load_val = (ONE << shamt) - ONE;
    assign expire   = en && !load && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load || expire) begin
            cnt <= load_val;
        end else if (en) begin
            cnt <= cnt - ONE;
        end
    end

    p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt));
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode,
    input  logic expire,
    input  logic ack,
    output logic irq,
    output logic sys_rst
);
    localparam int PC_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_LEN - 1);

    wd_state_e       state, state_nx;
    logic [PC_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            pcnt  <= '0;
        end else begin
            state <= state_nx;
            pcnt  <= (state == ST_RST) ? pcnt + PC_W'(1) : '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (en) state_nx = ST_RUN;
            ST_RUN: if (expire) state_nx = mode ? ST_IRQ : ST_RST;
            ST_IRQ: begin
                if (ack)         state_nx = ST_RUN;
                else if (expire) state_nx = ST_RST;
            end
            ST_RST: if (pcnt == PC_LAST) state_nx = ST_RUN;
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        irq     = (state == ST_IRQ);
        sys_rst = (state == ST_RST);
    end

    p_direct_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && expire && !mode) |=> (sys_rst && !irq));
    p_eoi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> !irq);
    p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> ($past(pcnt) == PC_LAST));
    p_escalate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && expire && !ack) |=> (sys_rst && !irq));
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph #(
    parameter int BASE_EXP  = 16,
    parameter int RANGE_W   = 4,
    parameter int ADDR_W    = 8,
    parameter int PULSE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    localparam int CNT_W = BASE_EXP + (1 << RANGE_W) - 1;

    logic               en_q, mode_q, en_set, kick, ack_rd, expire;
    logic [RANGE_W-1:0] range_q;
    logic [CNT_W-1:0]   cnt;

    wdog_regs #(.ADDR_W(ADDR_W), .RANGE_W(RANGE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt_val(cnt), .irq_pend(irq_o), .bus_rdata(bus_rdata),
        .en_q(en_q), .mode_q(mode_q), .range_q(range_q),
        .en_set(en_set), .kick(kick), .ack_rd(ack_rd)
    );

    wdog_counter #(.BASE_EXP(BASE_EXP), .RANGE_W(RANGE_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .load(en_set || kick || ack_rd), .range(range_q),
        .cnt(cnt), .expire(expire)
    );

    wdog_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q),
        .expire(expire), .ack(ack_rd), .irq(irq_o), .sys_rst(sys_rst_o)
    );
endmodule

// File: tb/wdog_periph_bench.sv
module wdog_periph_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #10 clk = ~clk;

    wdog_periph #(.BASE_EXP(2), .RANGE_W(4), .ADDR_W(8), .PULSE_LEN(8)) u_wdog_periph (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    endtask

    // monitor: samples a quarter period after the drive edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_sel && bus_rd) begin
                if (sb_q.size() == 0) begin
                    check("scoreboard underflow", 32'd1, 32'd0);
                end else begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int irq_first, irq_cnt, rst_first, rst_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        check("R3 reset irq", 32'(irq_o), 0);
        check("R3 reset sys_rst", 32'(sys_rst_o), 0);
        bus_read(8'h00, 32'h0, "R1 ctrl after reset");
        bus_read(8'h08, 32'h0, "R3 count after reset");
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, 32'h1, "R1 range readback");
        bus_read(8'h18, 32'h0, "R1 unmapped read");
        bus_write(8'h0C, 32'h76);
        bus_read(8'h14, 32'h0, "R3 ack read while disabled");
        bus_read(8'h08, 32'h0, "R3 count holds while disabled");
        bus_read(8'h10, 32'h0, "R3 status while disabled");
        // c0: enable, interrupt mode; period 2^(2+1)=8
        bus_write(8'h00, 32'h3);
        bus_read(8'h08, 32'd7, "R4 first load");
        bus_write(8'h00, 32'h2);
        bus_read(8'h00, 32'h3, "R2 enable sticky");
        bus_write(8'h0C, 32'h75);
        bus_read(8'h08, 32'd3, "R5 wrong key ignored");
        bus_write(8'h0C, 32'h76);
        bus_read(8'h08, 32'd7, "R5 key reload");
        bus_write(8'h04, 32'h0);
        bus_read(8'h08, 32'd5, "R6 range change waits");
        bus_write(8'h08, 32'h55);
        bus_read(8'h08, 32'd3, "R11 count write ignored");
        bus_read(8'h04, 32'h0, "R1 range readback zero");
        bus_read(8'h08, 32'd1, "R4 decrement");
        bus_read(8'h08, 32'd0, "R4 reaches zero");
        #5;
        check("R7 no irq before expiry", 32'(irq_o), 0);
        bus_read(8'h10, 32'h1, "R7 status pending");
        #5;
        check("R7 irq raised", 32'(irq_o), 1);
        bus_read(8'h08, 32'd2, "R6 new period after reload");
        bus_read(8'h14, 32'h0, "R8 ack read");
        irq_first = -1; irq_cnt = 0; rst_first = -1; rst_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            bus_idle();
            #5;
            if (i == 0) check("R8 irq cleared", 32'(irq_o), 0);
            if (irq_o) begin irq_cnt++; if (irq_first < 0) irq_first = i; end
            if (sys_rst_o) begin rst_cnt++; if (rst_first < 0) rst_first = i; end
        end
        check("R7 irq timing", 32'(irq_first), 32'd4);
        check("R9 irq drops at escalation", 32'(irq_cnt), 32'd4);
        check("R9 reset timing", 32'(rst_first), 32'd8);
        check("R9 reset pulse length", 32'(rst_cnt), 32'd8);
        bus_read(8'h00, 32'h3, "R2 enable kept after pulse");
        bus_read(8'h14, 32'h0, "R8 ack second irq");
        bus_write(8'h00, 32'h1);
        irq_cnt = 0; rst_first = -1; rst_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            bus_idle();
            #5;
            if (irq_o) irq_cnt++;
            if (sys_rst_o) begin rst_cnt++; if (rst_first < 0) rst_first = i; end
        end
        check("R10 no irq in direct mode", 32'(irq_cnt), 0);
        check("R10 direct reset timing", 32'(rst_first), 32'd3);
        check("R10 direct reset length", 32'(rst_cnt), 32'd8);
        bus_idle();
        bus_idle();
        check("scoreboard drained", 32'(sb_q.size()), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule